// File: doc/BRIEF.md
# BPSK Packet Transmitter

The block produces an unbroken stream of quadrature samples that carry fixed-length packets by binary phase shift keying. A packet starts whenever the previous one ends. A data packet is sent when a send request is waiting at the start of a packet. Otherwise an idle packet is sent. A data packet takes its payload from an external buffer through a synchronous address and combinational read-data pair. The buffer is filled by a processor before it raises the request.

Each packet starts with two fixed sync bytes. A type byte follows, then the payload, then a CRC byte. The CRC is computed over the type byte and the payload. Every byte after the sync bytes is combined with an additive scrambler sequence, and each byte is sent most significant bit first. Each bit takes eight samples and covers one full carrier cycle: a cosine on I and a sine on Q. A 1 sends the carrier as it is, and a 0 sends it negated.

A state machine moves through four states:
- HEADER: the two sync bytes.
- TYPE: the one type byte.
- PAYLOAD: the payload bytes.
- CRC: the check byte.

It has four transitions:
- HEADER to TYPE at the end of sync byte 1.
- TYPE to PAYLOAD at the end of the type byte.
- PAYLOAD to CRC at the end of the last payload byte.
- CRC to HEADER at the end of the check byte, which also starts the next packet.

Three counters pace it: a sample phase (0..7), a bit index (0..7) and a byte index.

Top module: `bpsk_tx`

## Requirements
- R1: While reset is held, out_valid, send_ack, out_i, out_q and pay_addr are all 0.
- R2: From the first rising clock edge after reset, out_valid is 1 on every cycle. Packets follow each other with no gap, and each is PKT_BYTES*64 samples long (2048 by default).
- R3: Packet layout, in time order: 0xFF, 0xF0, a type byte, PKT_BYTES-4 payload bytes, then a CRC byte. Bytes are sent MSB first. The payload of an idle packet is all 0x00, and the payload of a data packet is buffer entries 0, 1, 2 and so on, in that order.
- R4: The type byte, before scrambling, is 0xC5 for an idle packet and 0xA6 for a data packet.
- R5: The CRC register starts at 0x00 at the start of each packet and takes the unscrambled bits of the type and payload bytes, MSB first. Each bit updates it by computing fb = crc[7] xor bit, shifting left by one, and then XORing 0x07 when fb is 1 (generator x^8+x^2+x+1). Its final value is sent as the last byte.
- R6: The sync bytes are not scrambled. Every later bit is XORed with the output of a 7-bit register s that holds 0x7F at the first bit of the type byte. On each scrambled bit the output is s[6], then s becomes {s[5:0], s[6] xor s[5]} (x^7+x^6+1).
- R7: With sample phase p (0..7) within a bit, the cosine magnitudes C(p) are A, D, 0, -D, -A, -D, 0, D. Here A = AMP (32767 by default) and D = floor(A*46341/65536) (23169 by default).
- R8: Sample output follows R7. out_i = C(p) and out_q = C((p-2) mod 8) when the transmitted bit is 1, and both are negated when it is 0.
- R9: A one-cycle pulse on send_req is held until the next packet start. A request in the cycle just before that packet's first sample still counts for that packet. When a request is taken, send_ack is 1 for exactly the cycle in which that packet's first sample is on the outputs, and the packet is a data packet.
- R10: Any number of requests that arrive before one packet start produce exactly one data packet. The packet after it is idle unless a new request comes.
- R11: pay_addr equals k-3 while payload byte k (3 to PKT_BYTES-2) is being serialized, is 0 outside the payload, and changes only when a byte ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| send_req | input | 1 | Request to send the buffer contents |
| send_ack | output | 1 | Pulse marking the first sample of a data packet |
| pay_addr | output | $clog2(PKT_BYTES-4) | Payload buffer read address |
| pay_data | input | 8 | Payload byte at pay_addr (combinational read) |
| out_valid | output | 1 | Sample strobe, high in every cycle after reset |
| out_i | output | SW | In-phase sample, signed |
| out_q | output | SW | Quadrature sample, signed |

## Verification
The bench demodulates each packet from the sign of the I sample at phase 0. It then checks the sync, type, payload and CRC bytes separately, against bytes it computes itself, and compares every sample of the waveform.

Several faults would show up in these checks:
- A design that scrambled the sync bytes, reloaded the scrambler at the wrong byte, or fed scrambled bits into the CRC would corrupt the bytes after the sync bytes.
- Swapping the sine and cosine phase would show up as a waveform mismatch.

The request cases go after the handshake edges. One request arrives in the very cycle before a packet start, which a design that samples too late would push a whole packet back. Two requests arrive within one packet, which a design that counted requests would turn into two data packets. The payload sweeps cover all-zero, all-one, counting and mixed patterns, which exposes byte-order and address off-by-one errors.

// File: rtl/bpsk_tx_pkg.sv
package bpsk_tx_pkg;

    typedef enum logic [1:0] {
        ST_HEADER,
        ST_TYPE,
        ST_PAYLOAD,
        ST_CRC
    } tx_state_t;

    localparam int          SAMPLES_PER_BIT = 8;
    localparam int          HDR_BYTES       = 2;
    localparam logic [7:0]  SYNC_FIRST      = 8'hFF;
    localparam logic [7:0]  SYNC_SECOND     = 8'hF0;
    localparam logic [7:0]  KIND_IDLE       = 8'hC5;
    localparam logic [7:0]  KIND_DATA       = 8'hA6;
    localparam logic [7:0]  CRC_GEN         = 8'h07;
    localparam logic [6:0]  SCR_SEED        = 7'h7F;

endpackage

// File: rtl/bpsk_tx_scrambler.sv
module bpsk_tx_scrambler
    import bpsk_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic seq_bit
);

    logic [6:0] lfsr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr <= SCR_SEED;
        end else if (load) begin
            lfsr <= SCR_SEED;
        end else if (step) begin
            lfsr <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
        end
    end

    assign seq_bit = lfsr[6];

    // R6
    scr_state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != 7'd0);

endmodule

// File: rtl/bpsk_tx_crc8.sv
module bpsk_tx_crc8
    import bpsk_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [7:0] crc
);

    logic fb;
    assign fb = crc[7] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 8'd0;
        end else if (clr) begin
            crc <= 8'd0;
        end else if (en) begin
            crc <= {crc[6:0], 1'b0} ^ (fb ? CRC_GEN : 8'd0);
        end
    end

endmodule

// File: rtl/bpsk_tx_carrier.sv
module bpsk_tx_carrier #(
    parameter int SW  = 16,
    parameter int AMP = 32767
) (
    input  logic                 [2:0]    phase,
    input  logic                          bit_val,
    output logic signed          [SW-1:0] smp_i,
    output logic signed          [SW-1:0] smp_q
);

    localparam logic [47:0]             PROD = 48'(AMP) * 48'd46341;
    localparam logic signed [SW-1:0]    PA   = SW'(AMP);
    localparam logic signed [SW-1:0]    PD   = SW'(PROD >> 16);

    function automatic logic signed [SW-1:0] cos_at(input logic [2:0] p);
        logic signed [SW-1:0] v;
        unique case (p)
            3'd0:    v = PA;
            3'd1:    v = PD;
            3'd2:    v = '0;
            3'd3:    v = -PD;
            3'd4:    v = -PA;
            3'd5:    v = -PD;
            3'd6:    v = '0;
            default: v = PD;
        endcase
        return v;
    endfunction

    logic signed [SW-1:0] c_val;
    logic signed [SW-1:0] s_val;

    always_comb begin
        c_val = cos_at(phase);
        s_val = cos_at(phase - 3'd2);
        smp_i = bit_val ? c_val : -c_val;
        smp_q = bit_val ? s_val : -s_val;
    end

endmodule

// File: rtl/bpsk_tx.sv
module bpsk_tx
    import bpsk_tx_pkg::*;
#(
    parameter int PKT_BYTES = 32,
    parameter int SW        = 16,
    parameter int AMP       = 32767,
    localparam int PAY_BYTES = PKT_BYTES - HDR_BYTES - 2,
    localparam int AW        = $clog2(PAY_BYTES),
    localparam int BCW       = $clog2(PKT_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send_req,
    output logic                 send_ack,
    output logic [AW-1:0]        pay_addr,
    input  logic [7:0]           pay_data,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_i,
    output logic signed [SW-1:0] out_q
);

    localparam logic [BCW-1:0] LAST_BYTE = BCW'(PKT_BYTES - 1);
    localparam logic [BCW-1:0] LAST_PAY  = BCW'(PKT_BYTES - 2);
    localparam logic [BCW-1:0] LAST_HDR  = BCW'(HDR_BYTES - 1);

    tx_state_t      state, state_nx;
    logic [2:0]     phase;
    logic [2:0]     bit_idx;
    logic [BCW-1:0] byte_idx;
    logic           bit_end, byte_end, pkt_start;
    logic           pending, is_data, take;
    logic [7:0]     raw_byte, crc_val;
    logic           raw_bit, scr_bit, scr_on, tx_bit;
    logic signed [SW-1:0] car_i, car_q;

    assign bit_end   = (phase == 3'd7);
    assign byte_end  = bit_end && (bit_idx == 3'd7);
    assign pkt_start = (state == ST_HEADER) && (byte_idx == '0)
                       && (bit_idx == 3'd0) && (phase == 3'd0);
    assign take      = pending | send_req;

    // pacing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= 3'd0;
            bit_idx  <= 3'd0;
            byte_idx <= '0;
        end else begin
            phase <= phase + 3'd1;
            if (bit_end)  bit_idx <= bit_idx + 3'd1;
            if (byte_end) byte_idx <= (byte_idx == LAST_BYTE) ? '0 : byte_idx + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HEADER;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HEADER:  if (byte_end && byte_idx == LAST_HDR) state_nx = ST_TYPE;
            ST_TYPE:    if (byte_end) state_nx = ST_PAYLOAD;
            ST_PAYLOAD: if (byte_end && byte_idx == LAST_PAY) state_nx = ST_CRC;
            ST_CRC:     if (byte_end) state_nx = ST_HEADER;
            default:    state_nx = ST_HEADER;
        endcase
    end

    // byte selection
    always_comb begin
        unique case (state)
            ST_HEADER:  raw_byte = byte_idx[0] ? SYNC_SECOND : SYNC_FIRST;
            ST_TYPE:    raw_byte = is_data ? KIND_DATA : KIND_IDLE;
            ST_PAYLOAD: raw_byte = is_data ? pay_data : 8'h00;
            ST_CRC:     raw_byte = crc_val;
            default:    raw_byte = 8'h00;
        endcase
    end

    assign raw_bit = raw_byte[3'd7 - bit_idx];
    assign scr_on  = (state != ST_HEADER);
    assign tx_bit  = raw_bit ^ (scr_on & scr_bit);

    bpsk_tx_scrambler u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pkt_start),
        .step    (bit_end & scr_on),
        .seq_bit (scr_bit)
    );

    bpsk_tx_crc8 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pkt_start),
        .en    (bit_end && (state == ST_TYPE || state == ST_PAYLOAD)),
        .din   (raw_bit),
        .crc   (crc_val)
    );

    bpsk_tx_carrier #(.SW(SW), .AMP(AMP)) u_car (
        .phase   (phase),
        .bit_val (tx_bit),
        .smp_i   (car_i),
        .smp_q   (car_q)
    );

    // outputs, request latch and buffer address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            send_ack  <= 1'b0;
            pending   <= 1'b0;
            is_data   <= 1'b0;
            pay_addr  <= '0;
        end else begin
            out_valid <= 1'b1;
            out_i     <= car_i;
            out_q     <= car_q;
            send_ack  <= pkt_start & take;
            if (pkt_start) begin
                is_data <= take;
                pending <= 1'b0;
            end else begin
                pending <= take;
            end
            if (byte_end) begin
                if (byte_idx >= BCW'(HDR_BYTES) && byte_idx < LAST_PAY)
                    pay_addr <= AW'(byte_idx - BCW'(HDR_BYTES));
                else
                    pay_addr <= '0;
            end
        end
    end

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_ack |=> !send_ack);

    // R9
    ack_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_ack |-> is_data);

    // R2
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_end |=> $stable(pay_addr));

    // R3
    state_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CRC && byte_end) |=> (state == ST_HEADER && byte_idx == '0));

endmodule

// File: tb/bpsk_tx_test.sv
module bpsk_tx_test;

    localparam int PKT  = 32;
    localparam int PAY  = PKT - 4;
    localparam int NSMP = PKT * 64;
    localparam int AMP  = 32767;
    localparam longint DIAG = (longint'(AMP) * 46341) >>> 16;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               send_req;
    logic               send_ack;
    logic [4:0]         pay_addr;
    logic [7:0]         pay_data;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    logic [7:0] mem [PAY];
    logic [7:0] raw [PKT];
    logic [7:0] expb [PKT];
    logic [7:0] rxb [PKT];
    logic       ebits [PKT*8];
    logic       rbits [PKT*8];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign pay_data = (int'(pay_addr) < PAY) ? mem[pay_addr] : 8'h00;

    bpsk_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_req  (send_req),
        .send_ack  (send_ack),
        .pay_addr  (pay_addr),
        .pay_data  (pay_data),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint cos_ref(input int p);
        case (p & 7)
            0: return AMP;
            1: return DIAG;
            2: return 0;
            3: return -DIAG;
            4: return -AMP;
            5: return -DIAG;
            6: return 0;
            default: return DIAG;
        endcase
    endfunction

    task automatic fill_mem(input int pat);
        for (int k = 0; k < PAY; k++) begin
            case (pat)
                0: mem[k] = 8'h00;
                1: mem[k] = 8'hFF;
                2: mem[k] = 8'(k);
                default: mem[k] = 8'(k * 37 + 11);
            endcase
        end
    endtask

    task automatic build_expected(input bit data);
        logic [7:0] c;
        logic [6:0] s;
        logic fb, d, o;
        raw[0] = 8'hFF;
        raw[1] = 8'hF0;
        raw[2] = data ? 8'hA6 : 8'hC5;
        for (int k = 0; k < PAY; k++) raw[3+k] = data ? mem[k] : 8'h00;
        c = 8'h00;
        for (int k = 2; k < PKT - 1; k++) begin
            for (int b = 7; b >= 0; b--) begin
                d  = raw[k][b];
                fb = c[7] ^ d;
                c  = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h07;
            end
        end
        raw[PKT-1] = c;
        s = 7'h7F;
        for (int k = 0; k < PKT; k++) begin
            for (int b = 7; b >= 0; b--) begin
                if (k < 2) begin
                    o = 1'b0;
                end else begin
                    o = s[6];
                    s = {s[5:0], s[6] ^ s[5]};
                end
                expb[k][b] = raw[k][b] ^ o;
                ebits[k*8 + (7-b)] = raw[k][b] ^ o;
            end
        end
    endtask

    task automatic run_packet(input bit data, input int pat, input bit exp_ack,
                              input int ra1, input int ra2, input string ack_req);
        int wave_bad, valid_bad, ack_late, addr_bad;
        longint first_act, first_exp, addr_act, addr_exp;
        bit ack0;
        if (data) fill_mem(pat);
        build_expected(data);
        wave_bad = 0; valid_bad = 0; ack_late = 0; addr_bad = 0;
        first_act = 0; first_exp = 0; addr_act = 0; addr_exp = 0; ack0 = 0;
        for (int j = 0; j < NSMP; j++) begin
            @(negedge clk);
            begin
                int p = j % 8;
                int bi = j / 8;
                longint ei = ebits[bi] ? cos_ref(p) : -cos_ref(p);
                longint eq = ebits[bi] ? cos_ref(p - 2) : -cos_ref(p - 2);
                if (longint'(out_i) != ei || longint'(out_q) != eq) begin
                    if (wave_bad == 0) begin first_act = out_i; first_exp = ei; end
                    wave_bad++;
                end
                if (p == 0) rbits[bi] = (out_i > 0);
                if (!out_valid) valid_bad++;
                if (j == 0) ack0 = send_ack;
                else if (send_ack) ack_late++;
                if (j % 64 == 10) begin
                    int k = j / 64;
                    longint ea = (k >= 3 && k <= PKT - 2) ? k - 3 : 0;
                    if (longint'(pay_addr) != ea) begin
                        if (addr_bad == 0) begin addr_act = pay_addr; addr_exp = ea; end
                        addr_bad++;
                    end
                end
            end
            send_req = (j == ra1) || (j == ra2);
        end
        for (int k = 0; k < PKT; k++)
            for (int b = 0; b < 8; b++) rxb[k][7-b] = rbits[k*8 + b];
        // R2: strobe high throughout, packet length back to back
        check(valid_bad == 0, "R2", valid_bad, 0);
        // R3: sync bytes
        check(rxb[0] == 8'hFF && rxb[1] == 8'hF0, "R3", {rxb[0], rxb[1]}, 16'hFFF0);
        // R4: scrambled type byte
        check(rxb[2] == expb[2], "R4", rxb[2], expb[2]);
        // R6: scrambled payload bytes
        begin
            int bad = 0;
            int at = 0;
            for (int k = 3; k < PKT - 1; k++)
                if (rxb[k] != expb[k]) begin if (bad == 0) at = k; bad++; end
            check(bad == 0, "R6", rxb[at], expb[at]);
        end
        // R5: CRC byte
        check(rxb[PKT-1] == expb[PKT-1], "R5", rxb[PKT-1], expb[PKT-1]);
        // R7 and R8: every sample of the carrier
        check(wave_bad == 0, "R8", first_act, first_exp);
        // R9 / R10: acknowledge on the first sample only
        check(ack0 == exp_ack && ack_late == 0, ack_req, {ack0, 31'(ack_late)}, {exp_ack, 31'd0});
        // R11: buffer address
        check(addr_bad == 0, "R11", addr_act, addr_exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        send_req = 1'b0;
        fill_mem(0);
        repeat (5) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(send_ack == 1'b0, "R1", send_ack, 0);
        check(out_i == 16'sd0 && out_q == 16'sd0, "R1", out_i, 0);
        check(pay_addr == 5'd0, "R1", pay_addr, 0);
        rst_n = 1'b1;
        // R7: carrier magnitude table check of the diagonal value
        check(DIAG == 23169, "R7", DIAG, 23169);
        run_packet(1'b0, 0, 1'b0, -1, -1, "R9");     // idle, no request
        run_packet(1'b0, 0, 1'b0, 1000, -1, "R9");   // request mid-packet
        run_packet(1'b1, 2, 1'b1, -1, -1, "R9");     // counting payload
        run_packet(1'b0, 0, 1'b0, NSMP - 1, -1, "R9"); // request in start cycle
        run_packet(1'b1, 1, 1'b1, 100, 1500, "R9");  // all ones; two requests
        run_packet(1'b1, 0, 1'b1, -1, -1, "R10");    // single data packet for both
        run_packet(1'b0, 0, 1'b0, NSMP - 2, -1, "R10"); // idle after it
        run_packet(1'b1, 3, 1'b1, -1, -1, "R9");     // mixed payload
        run_packet(1'b0, 0, 1'b0, -1, -1, "R10");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule